// File: doc/BRIEF.md
# Periodic Tick Timer with Missed-Period Counter

The block is a register-mapped tick timer. An 8-bit reloadable divider turns the system clock into a slower timebase: with a 25 MHz clock and a divider value of 0xE7 the timebase runs at 1 MHz. A 32-bit up-counter advances once per timebase pulse while the timer is running. It is compared against a period register; a value of 1000 at 1 MHz gives one match per millisecond.

Each match sets a sticky pending flag. When the flag is enabled, it drives an interrupt request at a programmable priority level. In periodic mode the counter returns to zero on every match. In free-running mode it runs on through the match and wraps at 2^32. A 4-bit match tally sits in the control register. Software reads it when it services the interrupt to learn how many periods went by, and a strobe bit clears it. This lets an interrupt handler recover ticks it was too late to see.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero, including the clear address (5), and irq_req is 0 with irq_level 0.
- R2: The divider is an 8-bit count that emits a timebase pulse on the cycle it holds 0xFF and then reloads with the divider register (address 1), so it divides by 256 minus that value (0xFF: every cycle, 0xE7: every 25 cycles). Writing address 1 stores the value and restarts the count at it at once.
- R3: The counter (address 3) advances by one per timebase pulse only while control bit 8 (run) is 1; with bit 8 at 0 it holds its value.
- R4: With control bit 9 (periodic) at 1, a timebase pulse that would bring the counter to the period value (address 2) is a match and sets the counter to 0, so the counter cycles through period values.
- R5: With control bit 9 at 0, the counter takes the period value on a match and keeps counting, wraps from 0xFFFFFFFF to 0, and matches again only when it next reaches the period value.
- R6: Control bits 15:12 hold a 4-bit match tally that increments on every match, wraps modulo 16, and ignores writes.
- R7: Writing the control register with bit 10 at 1 zeroes the tally; a match in the same cycle is counted after the clear (the tally becomes 1). Bit 10 always reads 0.
- R8: Status bit 25 (address 4, read-only) is set by a match and stays set until a write to address 5 with bit 25 at 1. Writes with bit 25 at 0 have no effect, and a match in the same cycle as the clear leaves the bit set.
- R9: irq_req is 1 exactly when status bit 25 and enable bit 25 (address 6) are both 1. irq_level then equals the 3-bit level in bits 6:4 of address 7, and it is 0 otherwise. Bit 7 of address 7 reads 0.
- R10: Software can write the counter directly at address 3; a write takes precedence over counting in that cycle.
- R11: Register map, word addresses: 0 control, 1 divider, 2 period, 3 counter, 4 status, 5 status clear, 6 enable, 7 level. Writes happen on the clock edge when bus_we is 1, and bus_rdata shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_req | output | 1 | Interrupt request, pending and enabled |
| irq_level | output | 3 | Priority level of the request, 0 when idle |

## Verification
The hardest situation to reach is a software action landing on the exact cycle of a match: a status clear, or a tally clear strobe, on the same edge where the counter reaches the period. The stimulus sets the divider to 0xFF so that every cycle is a timebase pulse. It selects free-running mode so only one match can occur, preloads the counter with zero, and then issues the clear a known number of cycles after the start write. This places it on the match edge by counting edges. Wrap at 2^32, tally wrap past 15, and the 25-cycle divider are reached with long runs whose final counter and tally values are predicted arithmetically.

// File: rtl/tick_pkg.sv
package tick_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int CNT_W  = 32;
    localparam int PRE_W  = 8;
    localparam int OVF_W  = 4;
    localparam int LVL_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd5;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd6;
    localparam logic [ADDR_W-1:0] A_LVL  = 3'd7;

    localparam int B_RUN  = 8;
    localparam int B_WRAP = 9;
    localparam int B_OCLR = 10;
    localparam int B_OVF  = 12;
    localparam int B_IRQ  = 25;
    localparam int B_LVL  = 4;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int W = tick_pkg::PRE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload,
    output logic         tick
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    assign tick = (st_q.cnt == TOP);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            st_d.cnt = reload;
        end else begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: unless the divide value is all ones, pulses never come back to back
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && reload != TOP) |=> !tick);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CW = tick_pkg::CNT_W,
    parameter int OW = tick_pkg::OVF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          wrap_mode,
    input  logic [CW-1:0] cmp,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          ovf_clr,
    output logic [CW-1:0] cnt,
    output logic [OW-1:0] ovf,
    output logic          match
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [OW-1:0] ovf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CW-1:0] cnt_inc;
    logic          step;

    assign cnt_inc = st_q.cnt + CW'(1);
    assign step    = tick && run && !cnt_we;
    assign match   = step && (cnt_inc == cmp);
    assign cnt     = st_q.cnt;
    assign ovf     = st_q.ovf;

    always_comb begin
        st_d = st_q;
        if (cnt_we) begin
            st_d.cnt = cnt_wdata;
        end else if (step) begin
            st_d.cnt = (match && wrap_mode) ? '0 : cnt_inc;
        end
        st_d.ovf = (ovf_clr ? '0 : st_q.ovf) + OW'(match);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a stopped, unwritten counter keeps its value
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(cnt));

    // R4: periodic mode returns to zero after a match
    assert_zero_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && wrap_mode) |=> (cnt == '0));

    // R6: each match without a clear adds one to the tally
    assert_tally_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !ovf_clr) |=> (ovf == $past(ovf) + OW'(1)));

    // R7: clear strobe without a match leaves a zero tally
    assert_tally_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !match) |=> (ovf == '0));
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [OVF_W-1:0]  ovf,
    input  logic              match,
    output logic [DATA_W-1:0] rdata,
    output logic              run,
    output logic              wrap_mode,
    output logic [PRE_W-1:0]  pre_val,
    output logic              pre_load,
    output logic [CNT_W-1:0]  cmp,
    output logic              cnt_we,
    output logic              ovf_clr,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level
);
    typedef struct packed {
        logic             run;
        logic             wrap;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cmp;
        logic             pend;
        logic             en;
        logic [LVL_W-1:0] lvl;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic wr_ctrl, wr_clr;

    assign wr_ctrl  = we && (addr == A_CTRL);
    assign wr_clr   = we && (addr == A_CLR) && wdata[B_IRQ];
    assign pre_load = we && (addr == A_PRE);
    assign cnt_we   = we && (addr == A_CNT);
    assign ovf_clr  = wr_ctrl && wdata[B_OCLR];

    assign run       = st_q.run;
    assign wrap_mode = st_q.wrap;
    assign pre_val   = wdata[PRE_W-1:0];
    assign cmp       = st_q.cmp;
    assign irq_req   = st_q.pend && st_q.en;
    assign irq_level = irq_req ? st_q.lvl : '0;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.run  = wdata[B_RUN];
            st_d.wrap = wdata[B_WRAP];
        end
        if (pre_load) begin
            st_d.pre = wdata[PRE_W-1:0];
        end
        if (we && addr == A_CMP) begin
            st_d.cmp = wdata[CNT_W-1:0];
        end
        if (we && addr == A_EN) begin
            st_d.en = wdata[B_IRQ];
        end
        if (we && addr == A_LVL) begin
            st_d.lvl = wdata[B_LVL +: LVL_W];
        end
        if (match) begin
            st_d.pend = 1'b1;
        end else if (wr_clr) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_OVF +: OVF_W] = ovf;
                rdata[B_RUN]          = st_q.run;
                rdata[B_WRAP]         = st_q.wrap;
            end
            A_PRE:   rdata[PRE_W-1:0] = st_q.pre;
            A_CMP:   rdata[CNT_W-1:0] = st_q.cmp;
            A_CNT:   rdata[CNT_W-1:0] = cnt;
            A_STAT:  rdata[B_IRQ]     = st_q.pend;
            A_EN:    rdata[B_IRQ]     = st_q.en;
            A_LVL:   rdata[B_LVL +: LVL_W] = st_q.lvl;
            default: rdata = '0;
        endcase
    end

    // R8: a match always leaves the pending flag set, clear or not
    assert_match_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq_req == st_q.en);

    // R8: without a clear, the pending flag never drops
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_clr && rdata[B_IRQ] && addr == A_STAT) |=> st_q.pend);

    // R9: the level pins stay quiet when the enable was off on the prior cycle and unchanged
    assert_quiet_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !(we && addr == A_EN)) |=> (irq_level == '0));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level
);
    logic             tick, run, wrap_mode, pre_load, cnt_we, ovf_clr, match;
    logic [PRE_W-1:0] pre_val, pre_reg;
    logic [CNT_W-1:0] cmp, cnt;
    logic [OVF_W-1:0] ovf;

    tick_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cnt       (cnt),
        .ovf       (ovf),
        .match     (match),
        .rdata     (bus_rdata),
        .run       (run),
        .wrap_mode (wrap_mode),
        .pre_val   (pre_val),
        .pre_load  (pre_load),
        .cmp       (cmp),
        .cnt_we    (cnt_we),
        .ovf_clr   (ovf_clr),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    assign pre_reg = u_regs.st_q.pre;

    tick_prescaler #(.W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pre_load),
        .load_val (pre_val),
        .reload   (pre_reg),
        .tick     (tick)
    );

    tick_counter #(.CW(CNT_W), .OW(OVF_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (run),
        .wrap_mode (wrap_mode),
        .cmp       (cmp),
        .cnt_we    (cnt_we),
        .cnt_wdata (bus_wdata[CNT_W-1:0]),
        .ovf_clr   (ovf_clr),
        .cnt       (cnt),
        .ovf       (ovf),
        .match     (match)
    );
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [2:0]  irq_level;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        bit          pins;
        string       tag;
    } item_t;

    item_t sb[$];
    event  sample_ev;

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_level(irq_level)
    );

    always #2 clk = ~clk;

    localparam logic [31:0] IRQB = 32'h0200_0000;

    // all tasks are entered on a falling edge and return on one
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [2:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        sb.push_back('{exp: e, pins: 1'b0, tag: tag});
        #1 -> sample_ev;
        @(negedge clk);
    endtask

    task automatic chk_irq(input bit r, input logic [2:0] l, input string tag);
        sb.push_back('{exp: {28'd0, r, l}, pins: 1'b1, tag: tag});
        #1 -> sample_ev;
        @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = it.pins ? {28'd0, irq_req, irq_level} : bus_rdata;
                vectors++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : driver
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 8; a++) chk(3'(a), 32'd0, "R1 reset register");
        chk_irq(1'b0, 3'd0, "R1 reset irq");

        // R2 divide by one from here on
        wr(3'd1, 32'h0000_00FF);
        chk(3'd1, 32'h0000_00FF, "R2 divider readback");

        // R10 direct counter write, R3 hold while stopped
        wr(3'd3, 32'h0000_0100);
        chk(3'd3, 32'h0000_0100, "R10 counter write");
        idle(10);
        chk(3'd3, 32'h0000_0100, "R3 stopped holds");
        wr(3'd0, 32'h0000_0100);
        idle(49);
        wr(3'd0, 32'h0);
        chk(3'd3, 32'h0000_0132, "R3 counts per tick");
        idle(5);
        chk(3'd3, 32'h0000_0132, "R3 stopped after run");

        // R4 periodic mode, R6 tally, R8 status
        wr(3'd0, 32'h0000_0400);
        chk(3'd0, 32'h0, "R7 clear bit reads zero");
        wr(3'd3, 32'h0);
        wr(3'd2, 32'd7);
        wr(3'd0, 32'h0000_0300);
        idle(99);
        wr(3'd0, 32'h0);
        chk(3'd3, 32'd2, "R4 periodic counter 100 mod 7");
        chk(3'd0, 32'h0000_E000, "R6 tally 14");
        chk(3'd4, IRQB, "R8 status set by match");
        wr(3'd5, 32'h0);
        chk(3'd4, IRQB, "R8 zero write ignored");
        wr(3'd5, IRQB);
        chk(3'd4, 32'h0, "R8 one write clears");

        // R6 tally wrap past 15
        wr(3'd0, 32'h0000_0400);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h0000_0300);
        idle(118);
        wr(3'd0, 32'h0);
        chk(3'd3, 32'd0, "R4 counter after 17 periods");
        chk(3'd0, 32'h0000_1000, "R6 tally wraps to 1");
        wr(3'd0, 32'h0000_F000);
        chk(3'd0, 32'h0000_1000, "R6 tally ignores writes");

        // R5 free-running wrap at 2^32
        wr(3'd5, IRQB);
        wr(3'd0, 32'h0000_0400);
        wr(3'd3, 32'hFFFF_FFF0);
        wr(3'd2, 32'd5);
        wr(3'd0, 32'h0000_0100);
        idle(29);
        wr(3'd0, 32'h0);
        chk(3'd3, 32'h0000_000E, "R5 counter wrapped");
        chk(3'd0, 32'h0000_1000, "R5 single match across wrap");
        chk(3'd4, IRQB, "R5 match sets status");

        // R8 match and clear on the same edge
        wr(3'd5, IRQB);
        wr(3'd3, 32'h0);
        wr(3'd2, 32'd10);
        wr(3'd0, 32'h0000_0100);
        idle(9);
        wr(3'd5, IRQB);
        wr(3'd0, 32'h0);
        chk(3'd4, IRQB, "R8 match wins over clear");

        // R7 tally clear on the match edge
        wr(3'd5, IRQB);
        wr(3'd0, 32'h0000_0400);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h0000_0100);
        idle(9);
        wr(3'd0, 32'h0000_0500);
        wr(3'd0, 32'h0);
        chk(3'd0, 32'h0000_1000, "R7 match counted after clear");

        // R9 interrupt gating and level
        chk_irq(1'b0, 3'd0, "R9 disabled request quiet");
        wr(3'd7, 32'h0000_0060);
        wr(3'd6, IRQB);
        chk_irq(1'b1, 3'd6, "R9 request at level 6");
        chk(3'd6, IRQB, "R9 enable readback");
        wr(3'd7, 32'h0000_00F0);
        chk(3'd7, 32'h0000_0070, "R9 level field bits 6:4");
        chk_irq(1'b1, 3'd7, "R9 request at level 7");
        wr(3'd5, IRQB);
        chk_irq(1'b0, 3'd0, "R9 cleared request quiet");
        chk(3'd5, 32'h0, "R11 clear address reads zero");

        // R2 divide by 25
        wr(3'd0, 32'h0000_0400);
        wr(3'd3, 32'h0);
        wr(3'd2, 32'd1000);
        wr(3'd1, 32'h0000_00E7);
        wr(3'd0, 32'h0000_0300);
        idle(248);
        wr(3'd0, 32'h0);
        chk(3'd3, 32'd10, "R2 one tick per 25 cycles");
        chk(3'd1, 32'h0000_00E7, "R2 divider value kept");

        idle(2);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule